// File: doc/BRIEF.md
# SD Host Command Issue and Status Controller

This block sits between a host's register port and the card-side command path of an SD-style host. Software loads a 32-bit argument in two 16-bit halves and then writes a 16-bit command word. The block decodes that word and raises a request carrying the command index and the argument. It holds the request until the card side returns a response made of up to sixteen bytes and a byte count. In the cycle the response is taken, the block classifies it against the response type the command expected, updates a write-one-to-clear status register and stores the response as eight 16-bit words.

An interrupt line is high whenever a status bit is set and the matching enable bit is set. A rising edge on the card-detect input also sets a status bit. Clearing the enable bit of the control register returns the block to its reset state. Card detect and all inputs are taken as synchronous to the clock. Response byte k arrives on bits 8k+7:8k of the response data bus, with byte 0 received first.

Register addresses, 4 bits wide: 0 command word (reads back the last accepted word), 1 argument bits 15:0, 2 argument bits 31:16, 3 control (bit 11 enable), 4 status, 5 interrupt enable, 8+w response word w. Addresses 6 and 7 read zero.

Top module: `sdcmd_ctrl`

## Requirements
- R1: The command word is decoded as index [5:0], init [7], response type [10:8], busy [11], command type [13:12] and direction [15]. A command write while the control enable bit (bit 11) is clear has no effect: no request is raised and the command register keeps its value.
- R2: Writing the control register with bit 11 clear drops any pending request and zeroes the status, interrupt enable, argument, command and response registers.
- R3: A command with init set and index 0 sets status bit 0 in the cycle it is written, and raises no request.
- R4: Any other accepted command raises req_valid, with req_index and req_arg fixed as they were at issue, until a cycle with rsp_valid high. Command writes made while the request is pending are ignored.
- R5: Response types 1, 3 and 6 need at least 4 bytes and type 2 needs 16. If fewer bytes arrive, status bit 7 is set instead of bit 0, and no response words are stored.
- R6: For type 1 (busy or not), the word {byte0,byte1,byte2,byte3} is ANDed with the card error mask 0xFDF90000. A nonzero result sets status bit 14.
- R7: For type 6, a nonzero result of {byte2,byte3} AND 0xE000 sets status bit 14.
- R8: A successful response to command index 12 sets status bits 0 and 2. Any other successful response sets bit 0 alone.
- R9: Response word 7-k is {byte 2k, byte 2k+1}. All eight words are taken from the bus lanes regardless of the count. All words are zeroed when a command is accepted.
- R10: A write to either argument address replaces only that 16-bit half.
- R11: A status write clears exactly the bits written as one. A set event in the same cycle wins.
- R12: The interrupt enable register keeps bits 14:0, and bit 15 reads zero. irq is high exactly when status AND enable is nonzero.
- R13: A rising edge of card_detect sets status bit 1. A steady high level or a falling edge sets nothing.
- R14: Response type codes 0, 4, 5 and 7 expect no response. Any reply counts as success, and no words are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| req_valid | output | 1 | Command request pending |
| req_index | output | 6 | Command index of the pending request |
| req_arg | output | 32 | Argument of the pending request |
| rsp_valid | input | 1 | Response present, taken while req_valid is high |
| rsp_len | input | 5 | Number of response bytes delivered |
| rsp_data | input | 128 | Response bytes, byte k on bits 8k+7:8k |
| card_detect | input | 1 | Card presence level |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a second command write that lands while a request is still outstanding. From the ports it looks like an ordinary write, yet it must leave the index, the argument and the command register untouched. The stimulus holds back the response on purpose, issues the second write in that window and only then answers. The response table also pairs each type with byte counts one short of its minimum, and with error bits placed just inside and just outside the mask. It covers a timed-out stop command, which must show the timeout bit and not bits 0 and 2.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int REG_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CMD   = 4'd0;
  localparam logic [ADDR_W-1:0] A_ARGLO = 4'd1;
  localparam logic [ADDR_W-1:0] A_ARGHI = 4'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd5;
  localparam logic [ADDR_W-1:0] A_RSP0  = 4'd8;

  localparam int CTRL_EN_BIT = 11;

  // command word field positions
  localparam int CW_IDX_LSB = 0;
  localparam int CW_INIT    = 7;
  localparam int CW_RT_LSB  = 8;

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_CD   = 1;
  localparam int ST_STOP = 2;
  localparam int ST_TMO  = 7;
  localparam int ST_CERR = 14;

  // expected response kinds
  localparam logic [2:0] RT_R1 = 3'd1;
  localparam logic [2:0] RT_R2 = 3'd2;
  localparam logic [2:0] RT_R3 = 3'd3;
  localparam logic [2:0] RT_R6 = 3'd6;
endpackage

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int IEN_BITS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  output logic              enable_o,
  output logic [2*REG_W-1:0] arg_o,
  output logic [REG_W-1:0]  ien_o,
  output logic [REG_W-1:0]  last_cmd_o,
  output logic              cmd_go_o,
  output logic              soft_clr_o
);
  localparam logic [REG_W-1:0] IEN_MASK = REG_W'((32'd1 << IEN_BITS) - 1);

  logic en_q, en_d, en_ce;
  logic [2*REG_W-1:0] arg_q, arg_d;
  logic arg_ce;
  logic [REG_W-1:0] ien_q, ien_d, cmd_q, cmd_d;
  logic ien_ce, cmd_ce;
  logic hit_cmd, hit_lo, hit_hi, hit_ctrl, hit_ien;

  always_comb begin
    hit_cmd  = wr_en && (addr == A_CMD);
    hit_lo   = wr_en && (addr == A_ARGLO);
    hit_hi   = wr_en && (addr == A_ARGHI);
    hit_ctrl = wr_en && (addr == A_CTRL);
    hit_ien  = wr_en && (addr == A_IEN);
    soft_clr_o = hit_ctrl && !wdata[CTRL_EN_BIT];
    cmd_go_o   = hit_cmd && en_q && !busy;

    en_ce = hit_ctrl;
    en_d  = wdata[CTRL_EN_BIT];

    arg_ce = soft_clr_o || hit_lo || hit_hi;
    arg_d  = arg_q;
    if (soft_clr_o)  arg_d = '0;
    else if (hit_lo) arg_d[REG_W-1:0] = wdata;
    else if (hit_hi) arg_d[2*REG_W-1:REG_W] = wdata;

    ien_ce = soft_clr_o || hit_ien;
    ien_d  = soft_clr_o ? '0 : (wdata & IEN_MASK);

    cmd_ce = soft_clr_o || cmd_go_o;
    cmd_d  = soft_clr_o ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      arg_q <= '0;
      ien_q <= '0;
      cmd_q <= '0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (arg_ce) arg_q <= arg_d;
      if (ien_ce) ien_q <= ien_d;
      if (cmd_ce) cmd_q <= cmd_d;
    end
  end

  assign enable_o   = en_q;
  assign arg_o      = arg_q;
  assign ien_o      = ien_q;
  assign last_cmd_o = cmd_q;

  assert_cmd_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmd && !en_q) |=> $stable(cmd_q));
  assert_arg_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |=> (arg_q[2*REG_W-1:REG_W] == $past(arg_q[2*REG_W-1:REG_W])));
  assert_ien_top_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ien |=> (ien_q[REG_W-1] == 1'b0));
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  parameter int LEN_W = $clog2(RSP_BYTES + 1),
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE000,
  parameter int STOP_IDX = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic [5:0]       cmd_index,
  input  logic             cmd_init,
  input  logic [2:0]       cmd_rtype,
  input  logic [31:0]      arg,
  input  logic             soft_clr,
  output logic             req_valid,
  output logic [5:0]       req_index,
  output logic [31:0]      req_arg,
  input  logic             rsp_valid,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic [31:0]      rsp_head,
  output logic             busy,
  output logic [REG_W-1:0] stat_set,
  output logic             cap_en
);
  typedef enum logic {S_IDLE, S_WAIT} state_e;
  state_e st_q, st_d;
  logic [5:0]  idx_q;
  logic [2:0]  rt_q;
  logic [31:0] arg_q;
  logic        lat_ce, init0, accept, short_rsp, has_rsp, cerr;
  logic [LEN_W-1:0] min_len;
  logic [31:0] r1_word;
  logic [15:0] r6_half;

  always_comb begin
    init0   = cmd_init && (cmd_index == 6'd0);
    accept  = (st_q == S_WAIT) && rsp_valid;
    r1_word = {rsp_head[7:0], rsp_head[15:8], rsp_head[23:16], rsp_head[31:24]};
    r6_half = {rsp_head[23:16], rsp_head[31:24]};
    unique case (rt_q)
      RT_R1, RT_R3, RT_R6: min_len = LEN_W'(4);
      RT_R2:               min_len = LEN_W'(RSP_BYTES);
      default:             min_len = '0;
    endcase
    has_rsp   = (min_len != '0);
    short_rsp = (rsp_len < min_len);
    cerr = ((rt_q == RT_R1) && |(r1_word & R1_ERR_MASK)) ||
           ((rt_q == RT_R6) && |(r6_half & R6_ERR_MASK));

    stat_set = '0;
    if (cmd_go && init0) stat_set[ST_DONE] = 1'b1;
    if (accept) begin
      if (short_rsp) stat_set[ST_TMO] = 1'b1;
      else begin
        stat_set[ST_DONE] = 1'b1;
        if (idx_q == 6'(STOP_IDX)) stat_set[ST_STOP] = 1'b1;
        if (cerr) stat_set[ST_CERR] = 1'b1;
      end
    end
    cap_en = accept && has_rsp && !short_rsp;

    lat_ce = cmd_go && !init0;
    st_d = st_q;
    if (soft_clr)    st_d = S_IDLE;
    else if (lat_ce) st_d = S_WAIT;
    else if (accept) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      rt_q  <= '0;
      arg_q <= '0;
    end else begin
      st_q <= st_d;
      if (lat_ce) begin
        idx_q <= cmd_index;
        rt_q  <= cmd_rtype;
        arg_q <= arg;
      end
    end
  end

  assign busy      = (st_q == S_WAIT);
  assign req_valid = busy;
  assign req_index = idx_q;
  assign req_arg   = arg_q;

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid && !soft_clr) |=>
      (req_valid && $stable(req_index) && $stable(req_arg)));
  assert_init0_noreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_init && (cmd_index == 6'd0) && !req_valid) |=> !req_valid);
  assert_clr_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !req_valid);
endmodule

// File: rtl/sdcmd_rspbuf.sv
module sdcmd_rspbuf
  import sdcmd_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  localparam int BPW = REG_W / 8,
  localparam int WORDS = RSP_BYTES / BPW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         cap,
  input  logic [8*RSP_BYTES-1:0]       data,
  output logic [WORDS-1:0][REG_W-1:0]  words_o
);
  logic [WORDS-1:0][REG_W-1:0] w_q, w_d;
  logic w_ce;

  assign w_ce = clr || cap;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int PAIR = WORDS - 1 - w;
    always_comb begin
      w_d[w] = '0;
      if (!clr) begin
        for (int j = 0; j < BPW; j++)
          w_d[w][REG_W-1-8*j -: 8] = data[8*(PAIR*BPW+j) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w_q <= '0;
    else if (w_ce) w_q <= w_d;
  end

  assign words_o = w_q;

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (w_q == '0));
endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_mask,
  input  logic             w1c_en,
  input  logic [REG_W-1:0] w1c_mask,
  input  logic             soft_clr,
  input  logic             card_detect,
  input  logic [REG_W-1:0] ien,
  output logic [REG_W-1:0] status_o,
  output logic             irq_o
);
  logic [REG_W-1:0] st_q, st_d, clr_m, cd_m;
  logic cd_q, cd_rise;

  always_comb begin
    cd_rise = card_detect && !cd_q;
    cd_m = '0;
    cd_m[ST_CD] = cd_rise;
    clr_m = w1c_en ? w1c_mask : '0;
    if (soft_clr) st_d = '0;
    else          st_d = (st_q & ~clr_m) | set_mask | cd_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      cd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      cd_q <= card_detect;
    end
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & ien);

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_en && (set_mask == '0) && !soft_clr && !(card_detect && !cd_q)) |=>
      ((st_q & $past(w1c_mask)) == '0));
  assert_cd_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (card_detect && !cd_q && !soft_clr) |=> st_q[ST_CD]);
  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (!$stable(st_q) || !$stable(ien)));
  assert_tmo_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(st_q[ST_TMO]) && $rose(st_q[ST_DONE])));
endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  parameter int LEN_W = $clog2(RSP_BYTES + 1),
  parameter int IEN_BITS = 15,
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter int STOP_IDX = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [3:0]             reg_addr,
  input  logic [15:0]            reg_wdata,
  output logic [15:0]            reg_rdata,
  output logic                   req_valid,
  output logic [5:0]             req_index,
  output logic [31:0]            req_arg,
  input  logic                   rsp_valid,
  input  logic [LEN_W-1:0]       rsp_len,
  input  logic [8*RSP_BYTES-1:0] rsp_data,
  input  logic                   card_detect,
  output logic                   irq
);
  localparam int WORDS  = RSP_BYTES / (REG_W / 8);
  localparam int RIDX_W = $clog2(WORDS);

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic enable, busy, cmd_go, soft_clr, cap_en;
  logic [31:0] arg;
  logic [REG_W-1:0] ien, last_cmd, status, stat_set;
  logic [WORDS-1:0][REG_W-1:0] words;
  logic [RIDX_W-1:0] ridx;

  sdcmd_regs #(.IEN_BITS(IEN_BITS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .enable_o(enable), .arg_o(arg),
    .ien_o(ien), .last_cmd_o(last_cmd), .cmd_go_o(cmd_go),
    .soft_clr_o(soft_clr)
  );

  sdcmd_engine #(
    .RSP_BYTES(RSP_BYTES), .LEN_W(LEN_W),
    .R1_ERR_MASK(R1_ERR_MASK), .STOP_IDX(STOP_IDX)
  ) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .cmd_go(cmd_go),
    .cmd_index(reg_wdata[CW_IDX_LSB +: 6]), .cmd_init(reg_wdata[CW_INIT]),
    .cmd_rtype(reg_wdata[CW_RT_LSB +: 3]), .arg(arg), .soft_clr(soft_clr),
    .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_head(rsp_data[31:0]),
    .busy(busy), .stat_set(stat_set), .cap_en(cap_en)
  );

  sdcmd_rspbuf #(.RSP_BYTES(RSP_BYTES)) u_rspbuf (
    .clk(clk), .rst_n(rst_sync_n), .clr(cmd_go || soft_clr), .cap(cap_en),
    .data(rsp_data), .words_o(words)
  );

  sdcmd_status u_status (
    .clk(clk), .rst_n(rst_sync_n), .set_mask(stat_set),
    .w1c_en(reg_wr && (reg_addr == A_STAT)), .w1c_mask(reg_wdata),
    .soft_clr(soft_clr), .card_detect(card_detect), .ien(ien),
    .status_o(status), .irq_o(irq)
  );

  always_comb begin
    ridx = RIDX_W'(reg_addr - A_RSP0);
    reg_rdata = '0;
    if (reg_addr >= A_RSP0) reg_rdata = words[ridx];
    else begin
      case (reg_addr)
        A_CMD:   reg_rdata = last_cmd;
        A_ARGLO: reg_rdata = arg[15:0];
        A_ARGHI: reg_rdata = arg[31:16];
        A_CTRL:  reg_rdata[CTRL_EN_BIT] = enable;
        A_STAT:  reg_rdata = status;
        A_IEN:   reg_rdata = ien;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/sdcmd_ctrl_tb.sv
module sdcmd_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic req_valid;
  logic [5:0] req_index;
  logic [31:0] req_arg;
  logic rsp_valid = 1'b0;
  logic [4:0] rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic card_detect = 1'b0;
  logic irq;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sdcmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_index(req_index), .req_arg(req_arg), .rsp_valid(rsp_valid),
    .rsp_len(rsp_len), .rsp_data(rsp_data), .card_detect(card_detect),
    .irq(irq)
  );

  localparam int NV = 14;
  localparam logic [15:0] VCMD [NV] = '{
    16'h0111, 16'h9907, 16'h0111, 16'h0202, 16'h0209, 16'h0329, 16'h0603,
    16'h0603, 16'h090C, 16'h0000, 16'h0508, 16'h010D, 16'h010C, 16'h020A};
  localparam logic [4:0] VLEN [NV] = '{
    5'd6, 5'd4, 5'd3, 5'd16, 5'd15, 5'd4, 5'd4,
    5'd5, 5'd4, 5'd0, 5'd16, 5'd4, 5'd0, 5'd16};
  localparam logic [127:0] VDATA [NV] = '{
    128'h0000_AA55_0009_0000,
    128'h0000_0080,
    128'h0001_0203,
    128'h0F0E0D0C_0B0A0908_07060504_03020100,
    128'h0F0E0D0C_0B0A0908_07060504_03020100,
    128'h80FF_8000,
    128'h0020_1234,
    128'hFF1F_5678,
    128'h0009_0000,
    128'h0,
    {128{1'b1}},
    128'h0000_0200,
    128'h0,
    {128{1'b1}}};
  localparam logic [15:0] VSTAT [NV] = '{
    16'h0001, 16'h4001, 16'h0080, 16'h0001, 16'h0080, 16'h0001, 16'h4001,
    16'h0001, 16'h0005, 16'h0001, 16'h0001, 16'h0001, 16'h0080, 16'h0001};
  localparam string VTAG [NV] = '{
    "R6", "R6", "R5", "R9", "R5", "R5", "R7",
    "R7", "R8", "R14", "R14", "R6", "R8", "R9"};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic respond(input logic [4:0] len, input logic [127:0] data);
    int n = 0;
    @(negedge clk);
    while (!req_valid && n < 50) begin @(negedge clk); n++; end
    rsp_valid = 1'b1; rsp_len = len; rsp_data = data;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input logic [127:0] d, input int w);
    int k = 7 - w;
    return {d[8*(2*k) +: 8], d[8*(2*k+1) +: 8]};
  endfunction

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(irq == 1'b0, "R12", "irq after reset", irq, 0);
    chk(req_valid == 1'b0, "R4", "req after reset", req_valid, 0);
    rd(4'd4, v); chk(v == 16'h0, "R11", "status after reset", v, 0);

    // R1: command ignored while disabled
    wr(4'd0, 16'h0111);
    repeat (2) @(negedge clk);
    chk(req_valid == 1'b0, "R1", "req while disabled", req_valid, 0);
    rd(4'd0, v); chk(v == 16'h0, "R1", "cmd reg while disabled", v, 0);

    wr(4'd3, 16'h0800);
    rd(4'd3, v); chk(v == 16'h0800, "R2", "ctrl enable readback", v, 16'h0800);

    // R10: argument halves
    wr(4'd1, 16'h1234);
    wr(4'd2, 16'hABCD);
    wr(4'd1, 16'h5678);
    rd(4'd2, v); chk(v == 16'hABCD, "R10", "arg high kept", v, 16'hABCD);
    rd(4'd1, v); chk(v == 16'h5678, "R10", "arg low replaced", v, 16'h5678);

    // R3: init with index 0
    wr(4'd0, 16'h0080);
    rd(4'd4, v); chk(v == 16'h0001, "R3", "init0 status", v, 16'h0001);
    repeat (2) @(negedge clk);
    chk(req_valid == 1'b0, "R3", "init0 raises no request", req_valid, 0);

    // response table
    for (int i = 0; i < NV; i++) begin
      bit cap;
      logic [2:0] rt;
      rt = VCMD[i][10:8];
      cap = (rt == 3'd1 || rt == 3'd2 || rt == 3'd3 || rt == 3'd6) && !VSTAT[i][7];
      wr(4'd4, 16'hFFFF);
      wr(4'd0, VCMD[i]);
      chk(req_valid == 1'b1, "R4", "request raised", req_valid, 1);
      chk(req_index == VCMD[i][5:0], "R4", "request index", req_index, VCMD[i][5:0]);
      if (i == 0) chk(req_arg == 32'hABCD5678, "R10", "request arg", req_arg, 32'hABCD5678);
      rd(4'd15, v); chk(v == 16'h0, "R9", "words cleared on issue", v, 0);
      respond(VLEN[i], VDATA[i]);
      chk(req_valid == 1'b0, "R4", "request released", req_valid, 0);
      rd(4'd4, v); chk(v == VSTAT[i], VTAG[i], $sformatf("status vec %0d", i), v, VSTAT[i]);
      for (int w = 0; w < 8; w++) begin
        logic [15:0] e;
        e = cap ? exp_word(VDATA[i], w) : 16'h0;
        rd(4'(8 + w), v);
        chk(v == e, "R9", $sformatf("vec %0d word %0d", i, w), v, e);
      end
    end

    // R4: second write during pending request is ignored
    wr(4'd4, 16'hFFFF);
    wr(4'd0, 16'h0111);
    wr(4'd0, 16'h0105);
    chk(req_index == 6'd17, "R4", "index held", req_index, 17);
    rd(4'd0, v); chk(v == 16'h0111, "R4", "cmd reg held", v, 16'h0111);
    respond(5'd4, 128'h0);
    rd(4'd4, v); chk(v == 16'h0001, "R4", "status after held cmd", v, 16'h0001);

    // R11: write-one-to-clear
    wr(4'd4, 16'hFFFF);
    wr(4'd0, 16'h0107);
    respond(5'd4, 128'h80);
    rd(4'd4, v); chk(v == 16'h4001, "R6", "error status", v, 16'h4001);
    wr(4'd4, 16'h0001);
    rd(4'd4, v); chk(v == 16'h4000, "R11", "only written bit cleared", v, 16'h4000);

    // R12: interrupt enable and line
    chk(irq == 1'b0, "R12", "irq with enables off", irq, 0);
    wr(4'd5, 16'hFFFF);
    rd(4'd5, v); chk(v == 16'h7FFF, "R12", "enable bit 15 dropped", v, 16'h7FFF);
    chk(irq == 1'b1, "R12", "irq on", irq, 1);
    wr(4'd5, 16'h0001);
    #1 chk(irq == 1'b0, "R12", "irq masked", irq, 0);
    wr(4'd5, 16'h4000);
    #1 chk(irq == 1'b1, "R12", "irq single enable", irq, 1);
    wr(4'd4, 16'h4000);
    #1 chk(irq == 1'b0, "R12", "irq after clear", irq, 0);

    // R13: card detect edge
    @(negedge clk); card_detect = 1'b1;
    rd(4'd4, v); chk(v == 16'h0002, "R13", "rise sets bit1", v, 16'h0002);
    wr(4'd4, 16'h0002);
    repeat (2) @(negedge clk);
    rd(4'd4, v); chk(v == 16'h0000, "R13", "level does not set", v, 0);
    @(negedge clk); card_detect = 1'b0;
    rd(4'd4, v); chk(v == 16'h0000, "R13", "fall does not set", v, 0);
    @(negedge clk); card_detect = 1'b1;
    rd(4'd4, v); chk(v == 16'h0002, "R13", "second rise", v, 16'h0002);

    // R2: clearing enable resets
    wr(4'd5, 16'h0002);
    wr(4'd0, 16'h0111);
    chk(req_valid == 1'b1, "R2", "pending before clear", req_valid, 1);
    wr(4'd3, 16'h0000);
    chk(req_valid == 1'b0, "R2", "request dropped", req_valid, 0);
    chk(irq == 1'b0, "R2", "irq after clear", irq, 0);
    rd(4'd4, v); chk(v == 16'h0, "R2", "status zero", v, 0);
    rd(4'd5, v); chk(v == 16'h0, "R2", "enable zero", v, 0);
    rd(4'd1, v); chk(v == 16'h0, "R2", "arg low zero", v, 0);
    rd(4'd2, v); chk(v == 16'h0, "R2", "arg high zero", v, 0);
    rd(4'd0, v); chk(v == 16'h0, "R2", "cmd zero", v, 0);
    wr(4'd0, 16'h0111);
    repeat (2) @(negedge clk);
    chk(req_valid == 1'b0, "R1", "disabled after clear", req_valid, 0);

    finish_run();
  end
endmodule